// File: doc/BRIEF.md
# Byte-Lane Dual-Port RAM with Resettable Output Stage

This block is a dual-port memory built from 9-bit byte lanes. The number of lanes per port is fixed at elaboration. The lane count decides how many bits of each write-enable bus are used; the remaining bits have no effect.

Two port arrangements are available:
- **Two-port mode.** Both ports can read and write the same array.
- **Split mode.** Port B only writes, port A only reads, and the word is twice as wide. Port B then drives every lane of that wide word from its double-width enable bus.

Every read first lands in a capture stage. An optional output register can follow it, with its own clock enable and a synchronous reset. That reset loads a reset value chosen at elaboration and never stalls the array.

Both ports share one clock. There is no valid/ready handshake and no back-pressure. A port takes a new request on every edge where its enable is high, and read data arrives at a fixed latency.

Top module: `bram_bytewide`

## Requirements
- R1: Lane k holds word bits [9k+8:9k]. It is written at a clock edge only when the port enable and write-enable bit k are both high. Every other lane of that word keeps its contents.
- R2: With one lane per port, each port uses only write-enable bit 0. Higher bits of either enable bus change nothing.
- R3: In two-port mode with four lanes, port A uses a_we[3:0] and port B uses b_we[3:0]. b_we[7:4] changes nothing.
- R4: In split mode, port B writes the double-width word under b_we[7:0], one bit per lane. Port A never writes, whatever its enable bus holds.
- R5: With the output register present and its clock enable high, data read at edge n appears on the output after edge n+1. It does not appear after edge n.
- R6: With the output register present, the output holds its value while the register clock enable is low.
- R7: A high output reset makes the output equal the port's reset value after the next edge. Without the output register, this reset takes priority over a read in the same cycle.
- R8: Writes and reads of the array continue while output reset is high. With the output register present, a read issued during reset appears on the first edge after reset is released.
- R9: Without the output register, read data appears on the output after the same edge that samples the request. The output holds while the port is idle.
- R10: A port that reads and writes one address at the same edge returns the word as it was before that write.
- R11: In two-port mode, a word written through either port can be read through the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| a_en | input | 1 | Port A request enable |
| a_we | input | 4 | Port A lane write enables |
| a_addr | input | ADDR_W | Port A word address |
| a_din | input | DATA_W | Port A write data |
| a_oce | input | 1 | Port A output register clock enable |
| a_orst | input | 1 | Port A output reset, synchronous |
| a_dout | output | DATA_W | Port A read data |
| b_en | input | 1 | Port B request enable |
| b_we | input | 8 | Port B lane write enables |
| b_addr | input | ADDR_W | Port B word address |
| b_din | input | DATA_W | Port B write data |
| b_oce | input | 1 | Port B output register clock enable |
| b_orst | input | 1 | Port B output reset, synchronous |
| b_dout | output | DATA_W | Port B read data |

## Verification
Lane masks are applied in three ways:
- Single-lane masks separate one lane from its neighbours.
- Masks that set only the unused upper bits would expose a wrong lane count.
- Random masks on alternating ports, checked against a behavioural array, catch cross-port and overlap mistakes.

Output-stage behaviour is told apart by a few directed cases:
- Reads issued during reset, and reads with the clock enable low, separate the capture stage from the output register.
- A read and write to the same address shows read-before-write ordering.
- Back-to-back reads of words that differ pin the exact latency edge.

// File: rtl/bram_pkg.sv
package bram_pkg;
  localparam int MAX_LANES = 4;

  function automatic int word_lanes(input int lanes, input bit split);
    return split ? 2 * lanes : lanes;
  endfunction
endpackage

// File: rtl/bram_we_decode.sv
module bram_we_decode #(
  parameter int WE_W  = 4,
  parameter int USE_W = 4
) (
  input  logic             en,
  input  logic [WE_W-1:0]  we,
  output logic [USE_W-1:0] mask
);
  // Only the low USE_W enable bits select lanes.
  assign mask = en ? we[USE_W-1:0] : '0;

  generate
    if (USE_W < WE_W) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^we[WE_W-1:USE_W];
    end
  endgenerate
endmodule

// File: rtl/bram_array.sv
module bram_array #(
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  parameter int ADDR_W = 6,
  localparam int W     = LANE_W * LANES,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [LANES-1:0]  a_mask,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [W-1:0]      a_din,
  input  logic [LANES-1:0]  b_mask,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [W-1:0]      b_din,
  output logic [W-1:0]      a_rdata,
  output logic [W-1:0]      b_rdata
);
  logic [W-1:0] mem [DEPTH];

  // Same-address writes from both ports are undefined; port A is applied last.
  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (b_mask[k]) mem[b_addr][k*LANE_W +: LANE_W] <= b_din[k*LANE_W +: LANE_W];
      if (a_mask[k]) mem[a_addr][k*LANE_W +: LANE_W] <= a_din[k*LANE_W +: LANE_W];
    end
  end

  assign a_rdata = mem[a_addr];
  assign b_rdata = mem[b_addr];
endmodule

// File: rtl/bram_out_stage.sv
module bram_out_stage #(
  parameter int           W       = 36,
  parameter bit           OUT_REG = 1'b1,
  parameter logic [W-1:0] SRVAL   = '0
) (
  input  logic         clk,
  input  logic         rd_en,
  input  logic [W-1:0] rd_data,
  input  logic         oce,
  input  logic         orst,
  output logic [W-1:0] dout
);
  logic [W-1:0] hold_q;

  generate
    if (OUT_REG) begin : g_reg
      logic [W-1:0] reg_q;
      // Capture stage is never touched by the output reset.
      always_ff @(posedge clk) begin
        if (rd_en) hold_q <= rd_data;
      end
      always_ff @(posedge clk) begin
        if (orst)     reg_q <= SRVAL;
        else if (oce) reg_q <= hold_q;
      end
      assign dout = reg_q;
    end else begin : g_noreg
      // Reset moves to the capture stage and wins over a read.
      always_ff @(posedge clk) begin
        if (orst)       hold_q <= SRVAL;
        else if (rd_en) hold_q <= rd_data;
      end
      assign dout = hold_q;
      logic unused_oce;
      assign unused_oce = oce;
    end
  endgenerate
endmodule

// File: rtl/bram_bytewide.sv
module bram_bytewide #(
  parameter int  LANE_W  = 9,
  parameter int  LANES   = 4,
  parameter int  ADDR_W  = 6,
  parameter bit  SDP     = 1'b0,
  parameter bit  OUT_REG = 1'b1,
  localparam int WORD_LANES = bram_pkg::word_lanes(LANES, SDP),
  localparam int DATA_W     = LANE_W * WORD_LANES,
  localparam int WEA_W      = bram_pkg::MAX_LANES,
  localparam int WEB_W      = 2 * bram_pkg::MAX_LANES,
  parameter logic [DATA_W-1:0] SRVAL_A = '0,
  parameter logic [DATA_W-1:0] SRVAL_B = '0
) (
  input  logic              clk,
  input  logic              a_en,
  input  logic [WEA_W-1:0]  a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_din,
  input  logic              a_oce,
  input  logic              a_orst,
  output logic [DATA_W-1:0] a_dout,
  input  logic              b_en,
  input  logic [WEB_W-1:0]  b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_din,
  input  logic              b_oce,
  input  logic              b_orst,
  output logic [DATA_W-1:0] b_dout
);
  logic [WORD_LANES-1:0] a_mask, b_mask;
  logic [DATA_W-1:0]     a_rdata, b_rdata;
  logic                  b_rd_en;

  generate
    if (SDP) begin : g_split
      // Port A is the read side only.
      assign a_mask  = '0;
      assign b_rd_en = 1'b0;
      logic unused_a_wr;
      assign unused_a_wr = ^{a_we, a_din};
    end else begin : g_two
      bram_we_decode #(.WE_W(WEA_W), .USE_W(WORD_LANES)) u_dec_a (
        .en(a_en), .we(a_we), .mask(a_mask)
      );
      assign b_rd_en = b_en;
    end
  endgenerate

  bram_we_decode #(.WE_W(WEB_W), .USE_W(WORD_LANES)) u_dec_b (
    .en(b_en), .we(b_we), .mask(b_mask)
  );

  bram_array #(.LANE_W(LANE_W), .LANES(WORD_LANES), .ADDR_W(ADDR_W)) u_array (
    .clk(clk),
    .a_mask(a_mask), .a_addr(a_addr), .a_din(a_din),
    .b_mask(b_mask), .b_addr(b_addr), .b_din(b_din),
    .a_rdata(a_rdata), .b_rdata(b_rdata)
  );

  bram_out_stage #(.W(DATA_W), .OUT_REG(OUT_REG), .SRVAL(SRVAL_A)) u_out_a (
    .clk(clk), .rd_en(a_en), .rd_data(a_rdata),
    .oce(a_oce), .orst(a_orst), .dout(a_dout)
  );

  bram_out_stage #(.W(DATA_W), .OUT_REG(OUT_REG), .SRVAL(SRVAL_B)) u_out_b (
    .clk(clk), .rd_en(b_rd_en), .rd_data(b_rdata),
    .oce(b_oce), .orst(b_orst), .dout(b_dout)
  );
endmodule

// File: rtl/bram_bytewide_chk.sv
module bram_bytewide_chk #(
  parameter int                DATA_W  = 36,
  parameter bit                OUT_REG = 1'b1,
  parameter logic [DATA_W-1:0] SRVAL_A = '0,
  parameter logic [DATA_W-1:0] SRVAL_B = '0
) (
  input logic              clk,
  input logic              a_en,
  input logic              a_oce,
  input logic              a_orst,
  input logic [DATA_W-1:0] a_dout,
  input logic              b_en,
  input logic              b_oce,
  input logic              b_orst,
  input logic [DATA_W-1:0] b_dout
);
  // Armed once both outputs have been reset to a defined value.
  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (a_orst && b_orst) armed <= 1'b1;
  end

  AST_SRVAL_ON_RST_A: assert property (@(posedge clk) disable iff (!armed)
    a_orst |=> (a_dout == SRVAL_A)); // R7
  AST_SRVAL_ON_RST_B: assert property (@(posedge clk) disable iff (!armed)
    b_orst |=> (b_dout == SRVAL_B)); // R7

  generate
    if (OUT_REG) begin : g_reg
      AST_OCE_LOW_HOLDS_A: assert property (@(posedge clk) disable iff (!armed)
        (!a_orst && !a_oce) |=> $stable(a_dout)); // R6
      AST_OCE_LOW_HOLDS_B: assert property (@(posedge clk) disable iff (!armed)
        (!b_orst && !b_oce) |=> $stable(b_dout)); // R6
    end else begin : g_noreg
      AST_IDLE_HOLDS_A: assert property (@(posedge clk) disable iff (!armed)
        (!a_orst && !a_en) |=> $stable(a_dout)); // R9
      AST_IDLE_HOLDS_B: assert property (@(posedge clk) disable iff (!armed)
        (!b_orst && !b_en) |=> $stable(b_dout)); // R9
    end
  endgenerate
endmodule

bind bram_bytewide bram_bytewide_chk #(
  .DATA_W(DATA_W), .OUT_REG(OUT_REG), .SRVAL_A(SRVAL_A), .SRVAL_B(SRVAL_B)
) u_chk (
  .clk(clk),
  .a_en(a_en), .a_oce(a_oce), .a_orst(a_orst), .a_dout(a_dout),
  .b_en(b_en), .b_oce(b_oce), .b_orst(b_orst), .b_dout(b_dout)
);

// File: tb/sim_bram_bytewide.sv
`timescale 1ns/1ps
module sim_bram_bytewide;
  localparam logic [35:0] SR0A = 36'h1F0F0F0F0;
  localparam logic [35:0] SR0B = 36'h0E1E2E3E4;
  localparam logic [71:0] SR1A = 72'hC3C3C3C3C3C3C3C3C3;
  localparam logic [71:0] SR1B = 72'h0;
  localparam logic [8:0]  SR2A = 9'h1AB;
  localparam logic [8:0]  SR2B = 9'h055;

  // {port_b, we[7:0], addr[5:0], data[35:0]}
  localparam logic [50:0] VEC [0:7] = '{
    {1'b0, 8'h0F, 6'd20, 36'h123456789},
    {1'b1, 8'h01, 6'd20, 36'hAAAAAAAAA},
    {1'b0, 8'h02, 6'd20, 36'h555555555},
    {1'b1, 8'h04, 6'd20, 36'h0F0F0F0F0},
    {1'b0, 8'h08, 6'd20, 36'hFEDCBA987},
    {1'b1, 8'h0A, 6'd21, 36'h0000FFFF0},
    {1'b0, 8'h05, 6'd21, 36'h3C3C3C3C3},
    {1'b1, 8'hF6, 6'd21, 36'h987654321}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  logic        a0_en, a0_oce, a0_orst, b0_en, b0_oce, b0_orst;
  logic [3:0]  a0_we;
  logic [7:0]  b0_we;
  logic [5:0]  a0_addr, b0_addr;
  logic [35:0] a0_din, b0_din, a0_dout, b0_dout;

  logic        a1_en, a1_oce, a1_orst, b1_en, b1_oce, b1_orst;
  logic [3:0]  a1_we;
  logic [7:0]  b1_we;
  logic [5:0]  a1_addr, b1_addr;
  logic [71:0] a1_din, b1_din, a1_dout, b1_dout;

  logic        a2_en, a2_oce, a2_orst, b2_en, b2_oce, b2_orst;
  logic [3:0]  a2_we;
  logic [7:0]  b2_we;
  logic [5:0]  a2_addr, b2_addr;
  logic [8:0]  a2_din, b2_din, a2_dout, b2_dout;

  logic [35:0] m0 [64];
  logic [71:0] m1 [64];
  logic [8:0]  m2 [64];

  bram_bytewide #(.LANES(4), .SDP(1'b0), .OUT_REG(1'b1), .SRVAL_A(SR0A), .SRVAL_B(SR0B)) u0 (
    .clk(clk), .a_en(a0_en), .a_we(a0_we), .a_addr(a0_addr), .a_din(a0_din),
    .a_oce(a0_oce), .a_orst(a0_orst), .a_dout(a0_dout),
    .b_en(b0_en), .b_we(b0_we), .b_addr(b0_addr), .b_din(b0_din),
    .b_oce(b0_oce), .b_orst(b0_orst), .b_dout(b0_dout));

  bram_bytewide #(.LANES(4), .SDP(1'b1), .OUT_REG(1'b0), .SRVAL_A(SR1A), .SRVAL_B(SR1B)) u1 (
    .clk(clk), .a_en(a1_en), .a_we(a1_we), .a_addr(a1_addr), .a_din(a1_din),
    .a_oce(a1_oce), .a_orst(a1_orst), .a_dout(a1_dout),
    .b_en(b1_en), .b_we(b1_we), .b_addr(b1_addr), .b_din(b1_din),
    .b_oce(b1_oce), .b_orst(b1_orst), .b_dout(b1_dout));

  bram_bytewide #(.LANES(1), .SDP(1'b0), .OUT_REG(1'b0), .SRVAL_A(SR2A), .SRVAL_B(SR2B)) u2 (
    .clk(clk), .a_en(a2_en), .a_we(a2_we), .a_addr(a2_addr), .a_din(a2_din),
    .a_oce(a2_oce), .a_orst(a2_orst), .a_dout(a2_dout),
    .b_en(b2_en), .b_we(b2_we), .b_addr(b2_addr), .b_din(b2_din),
    .b_oce(b2_oce), .b_orst(b2_orst), .b_dout(b2_dout));

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [71:0] merge(input logic [71:0] old_w, input logic [71:0] new_w,
                                        input logic [7:0] m, input int lanes);
    logic [71:0] r;
    r = old_w;
    for (int k = 0; k < 8; k++)
      if (k < lanes && m[k]) r[k*9 +: 9] = new_w[k*9 +: 9];
    return r;
  endfunction

  task automatic wr0(input bit pb, input logic [5:0] ad, input logic [7:0] we, input logic [35:0] d);
    @(negedge clk);
    if (pb) begin b0_en = 1; b0_we = we; b0_addr = ad; b0_din = d; end
    else    begin a0_en = 1; a0_we = we[3:0]; a0_addr = ad; a0_din = d; end
    @(negedge clk);
    a0_en = 0; a0_we = 0; b0_en = 0; b0_we = 0;
    m0[ad] = 36'(merge(72'(m0[ad]), 72'(d), pb ? we : {4'h0, we[3:0]}, 4));
  endtask

  task automatic rd0(input bit pb, input logic [5:0] ad, input string req);
    @(negedge clk);
    if (pb) begin b0_en = 1; b0_addr = ad; end else begin a0_en = 1; a0_addr = ad; end
    @(negedge clk);
    a0_en = 0; b0_en = 0;
    @(negedge clk);
    chk(req, pb ? 72'(b0_dout) : 72'(a0_dout), 72'(m0[ad]));
  endtask

  task automatic rd1(input logic [5:0] ad, input logic [71:0] exp, input string req);
    @(negedge clk);
    a1_en = 1; a1_addr = ad;
    @(negedge clk);
    a1_en = 0;
    chk(req, a1_dout, exp);
  endtask

  task automatic rd2(input bit pb, input logic [5:0] ad, input logic [8:0] exp, input string req);
    @(negedge clk);
    if (pb) begin b2_en = 1; b2_addr = ad; end else begin a2_en = 1; a2_addr = ad; end
    @(negedge clk);
    a2_en = 0; b2_en = 0;
    chk(req, pb ? 72'(b2_dout) : 72'(a2_dout), 72'(exp));
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [35:0] prev, nv;
    logic [71:0] d1, old4;
    a0_en = 0; a0_we = 0; a0_addr = 0; a0_din = 0; a0_oce = 1; a0_orst = 1;
    b0_en = 0; b0_we = 0; b0_addr = 0; b0_din = 0; b0_oce = 1; b0_orst = 1;
    a1_en = 0; a1_we = 0; a1_addr = 0; a1_din = 0; a1_oce = 1; a1_orst = 1;
    b1_en = 0; b1_we = 0; b1_addr = 0; b1_din = 0; b1_oce = 1; b1_orst = 1;
    a2_en = 0; a2_we = 0; a2_addr = 0; a2_din = 0; a2_oce = 1; a2_orst = 1;
    b2_en = 0; b2_we = 0; b2_addr = 0; b2_din = 0; b2_oce = 1; b2_orst = 1;
    repeat (3) @(negedge clk);

    // Fill all arrays while output resets are held (R8: writes continue under reset).
    for (int i = 0; i < 64; i++) begin
      m0[i] = 36'({$urandom(), $urandom()});
      m1[i] = 72'({$urandom(), $urandom(), $urandom()});
      m2[i] = 9'($urandom());
      a0_en = 1; a0_we = 4'hF; a0_addr = 6'(i); a0_din = m0[i];
      b1_en = 1; b1_we = 8'hFF; b1_addr = 6'(i); b1_din = m1[i];
      a2_en = 1; a2_we = 4'h1; a2_addr = 6'(i); a2_din = m2[i];
      @(negedge clk);
    end
    a0_en = 0; a0_we = 0; b1_en = 0; b1_we = 0; a2_en = 0; a2_we = 0;
    @(negedge clk);
    chk("R7 reset state u0 A", 72'(a0_dout), 72'(SR0A));
    chk("R7 reset state u0 B", 72'(b0_dout), 72'(SR0B));
    chk("R7 reset state u1 A", a1_dout, SR1A);
    chk("R7 reset state u2 A", 72'(a2_dout), 72'(SR2A));

    // R8: read issued during reset surfaces after release.
    a0_en = 1; a0_addr = 6'd5; b0_en = 1; b0_addr = 6'd6;
    @(negedge clk);
    a0_en = 0; b0_en = 0;
    a0_orst = 0; b0_orst = 0; a1_orst = 0; b1_orst = 0; a2_orst = 0; b2_orst = 0;
    chk("R7 output still reset value", 72'(a0_dout), 72'(SR0A));
    @(negedge clk);
    chk("R8 read under reset A", 72'(a0_dout), 72'(m0[5]));
    chk("R8 read under reset B", 72'(b0_dout), 72'(m0[6]));

    // Table walk: masked writes, read back through the other port (R1, R11).
    for (int v = 0; v < 8; v++) begin
      wr0(VEC[v][50], VEC[v][41:36], VEC[v][49:42], VEC[v][35:0]);
      rd0(!VEC[v][50], VEC[v][41:36], "R1 R11 table lane write");
    end

    // Random byte-masked writes on both ports, checked against the model (R1, R3).
    for (int i = 0; i < 200; i++)
      wr0(1'($urandom()), 6'($urandom()), 8'($urandom()), 36'({$urandom(), $urandom()}));
    for (int i = 0; i < 64; i++) begin
      rd0(1'b0, 6'(i), "R1 random sweep A");
      rd0(1'b1, 6'(i), "R11 random sweep B");
    end

    // R3: upper enable bits of port B alone write nothing.
    wr0(1'b1, 6'd13, 8'hF0, ~m0[13]);
    rd0(1'b0, 6'd13, "R3 b_we upper bits ignored");

    // R5: exact latency with two different words.
    m0[30] = 36'h111111111; m0[31] = 36'h222222222;
    wr0(1'b0, 6'd30, 8'h0F, 36'h111111111);
    wr0(1'b0, 6'd31, 8'h0F, 36'h222222222);
    rd0(1'b0, 6'd30, "R5 first read");
    @(negedge clk);
    a0_en = 1; a0_addr = 6'd31;
    @(negedge clk);
    a0_en = 0;
    chk("R5 not yet after one edge", 72'(a0_dout), 72'(m0[30]));
    @(negedge clk);
    chk("R5 arrives after second edge", 72'(a0_dout), 72'(m0[31]));

    // R6: clock enable low holds the output.
    @(negedge clk);
    prev = a0_dout;
    a0_oce = 0; a0_en = 1; a0_addr = 6'd7;
    @(negedge clk);
    a0_en = 0;
    @(negedge clk);
    chk("R6 oce low holds", 72'(a0_dout), 72'(prev));
    a0_oce = 1;
    @(negedge clk);
    chk("R6 oce high releases", 72'(a0_dout), 72'(m0[7]));

    // R8: write during reset lands in the array.
    @(negedge clk);
    a0_orst = 1; a0_en = 1; a0_we = 4'hF; a0_addr = 6'd9; a0_din = 36'h0ABCDEF01;
    @(negedge clk);
    a0_en = 0; a0_we = 0; a0_orst = 0;
    m0[9] = 36'h0ABCDEF01;
    chk("R7 reset during write", 72'(a0_dout), 72'(SR0A));
    rd0(1'b0, 6'd9, "R8 write under reset kept");

    // R10: read-before-write on one port.
    @(negedge clk);
    prev = m0[11]; nv = ~m0[11];
    a0_en = 1; a0_we = 4'hF; a0_addr = 6'd11; a0_din = nv;
    @(negedge clk);
    a0_en = 0; a0_we = 0;
    m0[11] = nv;
    @(negedge clk);
    chk("R10 old data returned", 72'(a0_dout), 72'(prev));
    rd0(1'b0, 6'd11, "R10 new data stored");

    // R4: split mode, port B wide write, port A cannot write.
    @(negedge clk);
    old4 = m1[4];
    d1 = 72'hFEDCBA9876543210AB;
    b1_en = 1; b1_we = 8'h81; b1_addr = 6'd3; b1_din = d1;
    a1_en = 1; a1_we = 4'hF; a1_addr = 6'd4; a1_din = ~old4;
    @(negedge clk);
    b1_en = 0; b1_we = 0; a1_en = 0; a1_we = 0;
    m1[3] = merge(m1[3], d1, 8'h81, 8);
    rd1(6'd3, m1[3], "R4 R9 wide lanes 0 and 7");
    rd1(6'd4, old4, "R4 port A write ignored");
    @(negedge clk);
    d1 = 72'h0123456789ABCDEF55;
    b1_en = 1; b1_we = 8'h7E; b1_addr = 6'd3; b1_din = d1;
    @(negedge clk);
    b1_en = 0; b1_we = 0;
    m1[3] = merge(m1[3], d1, 8'h7E, 8);
    rd1(6'd3, m1[3], "R4 wide lanes 1 to 6");

    // R7: without output register, reset beats a read.
    @(negedge clk);
    a1_orst = 1; a1_en = 1; a1_addr = 6'd3;
    @(negedge clk);
    a1_orst = 0; a1_en = 0;
    chk("R7 reset beats read u1", a1_dout, SR1A);

    // R2: single-lane ports use only enable bit 0.
    @(negedge clk);
    a2_en = 1; a2_we = 4'b1110; a2_addr = 6'd2; a2_din = ~m2[2];
    @(negedge clk);
    a2_en = 0; a2_we = 0;
    rd2(1'b0, 6'd2, m2[2], "R2 a_we upper bits ignored");
    @(negedge clk);
    b2_en = 1; b2_we = 8'hFE; b2_addr = 6'd2; b2_din = ~m2[2];
    @(negedge clk);
    b2_en = 0; b2_we = 0;
    rd2(1'b1, 6'd2, m2[2], "R2 b_we upper bits ignored");
    @(negedge clk);
    a2_en = 1; a2_we = 4'b0001; a2_addr = 6'd2; a2_din = 9'h0C3;
    @(negedge clk);
    a2_en = 0; a2_we = 0;
    m2[2] = 9'h0C3;
    rd2(1'b1, 6'd2, m2[2], "R2 R9 bit 0 writes lane");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule